// File: doc/BRIEF.md
# Banked Register RAM with Upward Stack

This block is a 128-byte internal data store for a small 8-bit core. Three kinds of access share it. A register-name port reaches one of eight working registers. Which of four 8-byte groups that register lives in is set by a 2-bit group-select input. A direct port addresses any byte with a 7-bit address. A stack engine keeps an 8-bit stack pointer and carries out push and pop requests against the same storage.

The low 32 bytes hold the four register groups. The core's status logic drives the group-select pins, and a core leaving reset selects group 0. The stack pointer leaves reset at 07h and is incremented before each push, so the first pushed byte lands at 08h, which is the first byte of group 1. A pop returns the byte at the pointer and then steps the pointer down. Software can load the pointer with any value to move the stack, for example into the scratch area above 2Fh. Two sticky flags report stack faults and colliding writes. All three read paths return their data one cycle after the request.

Top module: `banked_stack_ram`

## Requirements
- R1: A synchronous reset sets the stack pointer to 07h and clears both flags and all read-valid outputs. Reset leaves the RAM contents as they were.
- R2: With group-select value b (bit 1 high, bit 0 low) and register index n, the register-name port accesses RAM byte 8·b + n, for all four groups.
- R3: The direct port reads and writes any byte 00h..7Fh. Every read returns its data with a valid strobe in the cycle after the request, and a read sees the contents from before a write to the same byte in the same cycle.
- R4: An accepted push first increments the stack pointer, then writes the byte at the new pointer. After reset the first push lands at 08h.
- R5: An accepted pop returns the byte at the current pointer on the pop-data output with a valid strobe one cycle later, and decrements the pointer.
- R6: A pointer load sets the pointer to the given value. A push or pop requested in the same cycle is ignored: no RAM write and no pop data.
- R7: A push while the pointer is 7Fh or above sets the sticky stack-error flag. It writes no RAM byte and leaves the pointer unchanged.
- R8: A pop while the pointer is 00h or above 7Fh sets the sticky stack-error flag. It produces no pop data and leaves the pointer unchanged.
- R9: When an accepted push and a register-port write hit the same byte in one cycle, the pushed byte is stored, the register write is dropped and the sticky clash flag is set. When they hit different bytes, both are stored.
- R10: When push and pop are requested together without a load, only the pop is carried out. The pushed byte is not written.
- R11: When the register-name port and the direct port write the same byte in one cycle, the register-name port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Register group select (bit 1 high, bit 0 low) |
| rn_en | input | 1 | Register-name port request |
| rn_we | input | 1 | Register-name port write (1) or read (0) |
| rn_idx | input | 3 | Register index 0..7 |
| rn_wdata | input | 8 | Register write data |
| rn_rdata | output | 8 | Register read data |
| rn_rvalid | output | 1 | Register read data valid |
| dir_en | input | 1 | Direct port request |
| dir_we | input | 1 | Direct port write (1) or read (0) |
| dir_addr | input | 7 | Direct byte address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| dir_rvalid | output | 1 | Direct read data valid |
| push_req | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop request |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | Popped byte valid |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 8 | Value to load |
| sp_value | output | 8 | Current stack pointer |
| stack_err | output | 1 | Sticky stack fault flag |
| clash_flag | output | 1 | Sticky push/register-write collision flag |

## Verification
The bench uses the default parameters: a 7-bit byte address, an 8-bit stack pointer, and four groups of eight registers. With these values the pointer can hold values the RAM cannot reach. The bench drives it to 7Eh, 7Fh and 90h to test the overflow edge, and to 00h and 01h to test the underflow edge. The same values make the register groups overlap the default stack region, so a push into 08h can collide with a write to group 1, register 0. A reference model inside the bench predicts every read, pop and pointer value. It fills the whole RAM first so that every later read has a known expected value.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned RAM_ADDR_W   = 7;
  localparam int unsigned WORD_W       = 8;
  localparam int unsigned PTR_W        = 8;
  localparam int unsigned GROUP_SEL_W  = 2;
  localparam int unsigned REG_IDX_W    = 3;
  localparam logic [7:0]  PTR_RESET    = 8'h07;

  // Decoded stack operation for one cycle; load outranks pop, pop outranks push.
  typedef enum logic [1:0] {
    SOP_IDLE = 2'd0,
    SOP_LOAD = 2'd1,
    SOP_POP  = 2'd2,
    SOP_PUSH = 2'd3
  } stack_op_e;
endpackage

// File: rtl/bsr_group_map.sv
module bsr_group_map #(
  parameter int unsigned AW     = bsr_pkg::RAM_ADDR_W,
  parameter int unsigned GSEL_W = bsr_pkg::GROUP_SEL_W,
  parameter int unsigned IDX_W  = bsr_pkg::REG_IDX_W
) (
  input  logic [GSEL_W-1:0] group_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  output logic [AW-1:0]     byte_addr
);
  localparam int unsigned PAD_W = AW - GSEL_W - IDX_W;

  // A register sits at group * 2**IDX_W + index, so the group bits are the upper field.
  generate
    if (PAD_W == 0) begin : g_exact
      assign byte_addr = {group_sel, reg_idx};
    end else begin : g_pad
      assign byte_addr = {{PAD_W{1'b0}}, group_sel, reg_idx};
    end
  endgenerate
endmodule

// File: rtl/bsr_stack_ctrl.sv
module bsr_stack_ctrl
  import bsr_pkg::*;
#(
  parameter int unsigned AW      = RAM_ADDR_W,
  parameter int unsigned SPW     = PTR_W,
  parameter logic [SPW-1:0] SP_RST = SPW'(PTR_RESET)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_req,
  input  logic           pop_req,
  input  logic           sp_load,
  input  logic [SPW-1:0] sp_load_val,
  output logic [SPW-1:0] sp_q,
  output logic           push_fire,
  output logic [AW-1:0]  push_addr,
  output logic           pop_fire,
  output logic [AW-1:0]  pop_addr,
  output logic           stack_err
);
  localparam logic [SPW-1:0] TOP_BYTE = SPW'((1 << AW) - 1);

  stack_op_e      op;
  logic [SPW-1:0] sp_up;
  logic [SPW-1:0] sp_down;
  logic           push_bad;
  logic           pop_bad;
  logic           fault;

  always_comb begin
    if (sp_load)       op = SOP_LOAD;
    else if (pop_req)  op = SOP_POP;
    else if (push_req) op = SOP_PUSH;
    else               op = SOP_IDLE;
  end

  assign sp_up     = sp_q + 1'b1;
  assign sp_down   = sp_q - 1'b1;
  assign push_bad  = (sp_q >= TOP_BYTE);
  assign pop_bad   = (sp_q == '0) || (sp_q > TOP_BYTE);
  assign push_fire = (op == SOP_PUSH) && !push_bad;
  assign pop_fire  = (op == SOP_POP) && !pop_bad;
  assign push_addr = sp_up[AW-1:0];
  assign pop_addr  = sp_q[AW-1:0];
  assign fault     = ((op == SOP_PUSH) && push_bad) || ((op == SOP_POP) && pop_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= SP_RST;
      stack_err <= 1'b0;
    end else begin
      case (op)
        SOP_LOAD: sp_q <= sp_load_val;
        SOP_PUSH: if (!push_bad) sp_q <= sp_up;
        SOP_POP:  if (!pop_bad)  sp_q <= sp_down;
        default:  sp_q <= sp_q;
      endcase
      if (fault) stack_err <= 1'b1;
    end
  end

  assert_push_preinc_R4: assert property (@(posedge clk) disable iff (rst)
    push_fire |=> sp_q == $past(sp_q) + 1'b1);

  assert_pop_postdec_R5: assert property (@(posedge clk) disable iff (rst)
    pop_fire |=> sp_q == $past(sp_q) - 1'b1);

  assert_load_sets_ptr_R6: assert property (@(posedge clk) disable iff (rst)
    sp_load |=> sp_q == $past(sp_load_val));

  assert_overflow_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && !sp_load && sp_q >= TOP_BYTE) |=> (stack_err && $stable(sp_q)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);

  assert_underflow_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !sp_load && sp_q == '0) |=> (stack_err && $stable(sp_q)));
endmodule

// File: rtl/bsr_ram.sv
module bsr_ram #(
  parameter int unsigned AW  = bsr_pkg::RAM_ADDR_W,
  parameter int unsigned DW  = bsr_pkg::WORD_W,
  parameter int unsigned NWR = 3,
  parameter int unsigned NRD = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][DW-1:0]  wr_data,
  input  logic [NRD-1:0]          rd_en,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem     [DEPTH];
  logic [DEPTH-1:0] word_we;
  logic [DW-1:0]    word_wd [DEPTH];

  // Per-byte write select: the lowest-numbered write port that hits a byte owns it.
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [NWR-1:0] hit;
    logic [DW-1:0]  pick;
    for (genvar p = 0; p < NWR; p++) begin : g_hit
      assign hit[p] = wr_en[p] && (wr_addr[p] == AW'(w));
    end
    always_comb begin
      pick = '0;
      for (int p = NWR - 1; p >= 0; p--) begin
        if (hit[p]) pick = wr_data[p];
      end
    end
    assign word_we[w] = |hit;
    assign word_wd[w] = pick;
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (word_we[w]) mem[w] <= word_wd[w];
    end
  end

  // Registered read ports, read-before-write.
  always_ff @(posedge clk) begin
    for (int r = 0; r < NRD; r++) begin
      if (rst)            rd_data[r] <= '0;
      else if (rd_en[r])  rd_data[r] <= mem[rd_addr[r]];
    end
  end

  assert_port0_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en[0] |=> mem[$past(wr_addr[0])] == $past(wr_data[0]));
endmodule

// File: rtl/banked_stack_ram.sv
module banked_stack_ram
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = RAM_ADDR_W,
  parameter int unsigned DATA_W    = WORD_W,
  parameter int unsigned SP_WIDTH  = PTR_W,
  parameter int unsigned BANK_W    = GROUP_SEL_W,
  parameter int unsigned IDX_W     = REG_IDX_W,
  parameter logic [SP_WIDTH-1:0] SP_INIT = SP_WIDTH'(PTR_RESET)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BANK_W-1:0]   bank_sel,
  input  logic                rn_en,
  input  logic                rn_we,
  input  logic [IDX_W-1:0]    rn_idx,
  input  logic [DATA_W-1:0]   rn_wdata,
  output logic [DATA_W-1:0]   rn_rdata,
  output logic                rn_rvalid,
  input  logic                dir_en,
  input  logic                dir_we,
  input  logic [ADDR_W-1:0]   dir_addr,
  input  logic [DATA_W-1:0]   dir_wdata,
  output logic [DATA_W-1:0]   dir_rdata,
  output logic                dir_rvalid,
  input  logic                push_req,
  input  logic [DATA_W-1:0]   push_data,
  input  logic                pop_req,
  output logic [DATA_W-1:0]   pop_data,
  output logic                pop_valid,
  input  logic                sp_load,
  input  logic [SP_WIDTH-1:0] sp_load_val,
  output logic [SP_WIDTH-1:0] sp_value,
  output logic                stack_err,
  output logic                clash_flag
);
  localparam int unsigned NPORT = 3;
  localparam int unsigned P_STK = 0;
  localparam int unsigned P_REG = 1;
  localparam int unsigned P_DIR = 2;

  logic [ADDR_W-1:0] rn_addr;
  logic              push_fire;
  logic              pop_fire;
  logic [ADDR_W-1:0] push_addr;
  logic [ADDR_W-1:0] pop_addr;
  logic              rn_wr;
  logic              dir_wr;
  logic              clash_evt;

  logic [NPORT-1:0]             wr_en;
  logic [NPORT-1:0][ADDR_W-1:0] wr_addr;
  logic [NPORT-1:0][DATA_W-1:0] wr_data;
  logic [NPORT-1:0]             rd_en;
  logic [NPORT-1:0][ADDR_W-1:0] rd_addr;
  logic [NPORT-1:0][DATA_W-1:0] rd_data;

  bsr_group_map #(.AW(ADDR_W), .GSEL_W(BANK_W), .IDX_W(IDX_W)) u_map (
    .group_sel (bank_sel),
    .reg_idx   (rn_idx),
    .byte_addr (rn_addr)
  );

  bsr_stack_ctrl #(.AW(ADDR_W), .SPW(SP_WIDTH), .SP_RST(SP_INIT)) u_stack (
    .clk         (clk),
    .rst         (rst),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val),
    .sp_q        (sp_value),
    .push_fire   (push_fire),
    .push_addr   (push_addr),
    .pop_fire    (pop_fire),
    .pop_addr    (pop_addr),
    .stack_err   (stack_err)
  );

  assign rn_wr     = rn_en && rn_we;
  assign dir_wr    = dir_en && dir_we;
  assign clash_evt = push_fire && rn_wr && (push_addr == rn_addr);

  // Port order sets write priority: stack, then register name, then direct.
  always_comb begin
    wr_en[P_STK]   = push_fire;
    wr_addr[P_STK] = push_addr;
    wr_data[P_STK] = push_data;
    wr_en[P_REG]   = rn_wr;
    wr_addr[P_REG] = rn_addr;
    wr_data[P_REG] = rn_wdata;
    wr_en[P_DIR]   = dir_wr;
    wr_addr[P_DIR] = dir_addr;
    wr_data[P_DIR] = dir_wdata;
    rd_en[P_STK]   = pop_fire;
    rd_addr[P_STK] = pop_addr;
    rd_en[P_REG]   = rn_en && !rn_we;
    rd_addr[P_REG] = rn_addr;
    rd_en[P_DIR]   = dir_en && !dir_we;
    rd_addr[P_DIR] = dir_addr;
  end

  bsr_ram #(.AW(ADDR_W), .DW(DATA_W), .NWR(NPORT), .NRD(NPORT)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign pop_data  = rd_data[P_STK];
  assign rn_rdata  = rd_data[P_REG];
  assign dir_rdata = rd_data[P_DIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid  <= 1'b0;
      rn_rvalid  <= 1'b0;
      dir_rvalid <= 1'b0;
      clash_flag <= 1'b0;
    end else begin
      pop_valid  <= rd_en[P_STK];
      rn_rvalid  <= rd_en[P_REG];
      dir_rvalid <= rd_en[P_DIR];
      if (clash_evt) clash_flag <= 1'b1;
    end
  end

  assert_clash_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && !sp_load && rn_wr && push_addr == rn_addr && sp_value < SP_WIDTH'((1 << ADDR_W) - 1))
      |=> clash_flag);

  assert_pop_valid_origin_R5: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> ($past(pop_req) && !$past(sp_load)));

  assert_dual_push_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !sp_load && sp_value != '0 && sp_value < SP_WIDTH'((1 << ADDR_W) - 1))
      |=> sp_value == $past(sp_value) - 1'b1);
endmodule

// File: tb/banked_stack_ram_bench.sv
`timescale 1ns/1ps
module banked_stack_ram_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bank_sel;
  logic       rn_en, rn_we;
  logic [2:0] rn_idx;
  logic [7:0] rn_wdata;
  logic [7:0] rn_rdata;
  logic       rn_rvalid;
  logic       dir_en, dir_we;
  logic [6:0] dir_addr;
  logic [7:0] dir_wdata;
  logic [7:0] dir_rdata;
  logic       dir_rvalid;
  logic       push_req;
  logic [7:0] push_data;
  logic       pop_req;
  logic [7:0] pop_data;
  logic       pop_valid;
  logic       sp_load;
  logic [7:0] sp_load_val;
  logic [7:0] sp_value;
  logic       stack_err;
  logic       clash_flag;

  always #2 clk = ~clk;

  banked_stack_ram u_banked_stack_ram (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .rn_en(rn_en), .rn_we(rn_we), .rn_idx(rn_idx), .rn_wdata(rn_wdata),
    .rn_rdata(rn_rdata), .rn_rvalid(rn_rvalid),
    .dir_en(dir_en), .dir_we(dir_we), .dir_addr(dir_addr), .dir_wdata(dir_wdata),
    .dir_rdata(dir_rdata), .dir_rvalid(dir_rvalid),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .pop_data(pop_data), .pop_valid(pop_valid),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp_value(sp_value),
    .stack_err(stack_err), .clash_flag(clash_flag)
  );

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  logic [7:0] mmem [128];
  logic [7:0] msp;
  logic       exp_err, exp_clash;
  string      lbl_rn, lbl_dir, lbl_pop;

  logic [7:0] q_rn[$],  q_dir[$],  q_pop[$];
  string      l_rn[$],  l_dir[$],  l_pop[$];

  task automatic chk(input string lbl, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", lbl, act, exp);
    end
  endtask

  task automatic clear_inputs();
    bank_sel = '0; rn_en = 0; rn_we = 0; rn_idx = '0; rn_wdata = '0;
    dir_en = 0; dir_we = 0; dir_addr = '0; dir_wdata = '0;
    push_req = 0; push_data = '0; pop_req = 0; sp_load = 0; sp_load_val = '0;
  endtask

  // Reference model for the cycle about to be clocked, from the requirements.
  task automatic apply_model();
    logic [6:0] ra;
    logic [6:0] pa;
    logic       pushed;
    logic       rnw;
    ra = 7'({bank_sel, rn_idx});
    pa = '0;
    pushed = 0;
    rnw = rn_en && rn_we;
    if (rn_en && !rn_we) begin q_rn.push_back(mmem[ra]); l_rn.push_back(lbl_rn); end
    if (dir_en && !dir_we) begin q_dir.push_back(mmem[dir_addr]); l_dir.push_back(lbl_dir); end
    if (sp_load) msp = sp_load_val;
    else if (pop_req) begin
      if (msp == 8'h00 || msp > 8'h7F) exp_err = 1;
      else begin q_pop.push_back(mmem[msp[6:0]]); l_pop.push_back(lbl_pop); msp = msp - 1; end
    end else if (push_req) begin
      if (msp >= 8'h7F) exp_err = 1;
      else begin msp = msp + 1; pa = msp[6:0]; pushed = 1; mmem[pa] = push_data; end
    end
    if (rnw) begin
      if (pushed && pa == ra) exp_clash = 1;
      else mmem[ra] = rn_wdata;
    end
    if (dir_en && dir_we && !(pushed && pa == dir_addr) && !(rnw && ra == dir_addr))
      mmem[dir_addr] = dir_wdata;
  endtask

  task automatic tick();
    apply_model();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic dir_read(input logic [6:0] a, input string l);
    dir_en = 1; dir_we = 0; dir_addr = a; lbl_dir = l; tick();
  endtask

  task automatic do_reset();
    tick();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    msp = 8'h07; exp_err = 0; exp_clash = 0;
  endtask

  // Scoreboard monitor: each valid strobe pops the next prediction for its port.
  always @(negedge clk) begin
    if (rn_rvalid) begin
      if (q_rn.size() == 0) chk("R2 unexpected register read", 8'h01, 8'h00);
      else chk(l_rn.pop_front(), rn_rdata, q_rn.pop_front());
    end
    if (dir_rvalid) begin
      if (q_dir.size() == 0) chk("R3 unexpected direct read", 8'h01, 8'h00);
      else chk(l_dir.pop_front(), dir_rdata, q_dir.pop_front());
    end
    if (pop_valid) begin
      if (q_pop.size() == 0) chk("R5 unexpected pop data", 8'h01, 8'h00);
      else chk(l_pop.pop_front(), pop_data, q_pop.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    lbl_rn = ""; lbl_dir = ""; lbl_pop = "";
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    msp = 8'h07; exp_err = 0; exp_clash = 0;

    // R1 reset state
    chk("R1 sp after reset", sp_value, 8'h07);
    chk("R1 stack_err after reset", {7'b0, stack_err}, 8'h00);
    chk("R1 clash_flag after reset", {7'b0, clash_flag}, 8'h00);
    chk("R1 valids after reset", {5'b0, rn_rvalid, dir_rvalid, pop_valid}, 8'h00);

    // R3 fill all of RAM through the direct port, then spot-read
    for (int a = 0; a < 128; a++) begin
      dir_en = 1; dir_we = 1; dir_addr = 7'(a); dir_wdata = 8'(a * 5 + 3); tick();
    end
    for (int a = 8'h30; a < 128; a += 7) dir_read(7'(a), "R3 direct readback");

    // R3 read-first: register read and direct write to byte 02h in one cycle
    bank_sel = 2'd0; rn_en = 1; rn_we = 0; rn_idx = 3'd2; lbl_rn = "R3 read sees old byte";
    dir_en = 1; dir_we = 1; dir_addr = 7'h02; dir_wdata = 8'hD2; tick();
    dir_read(7'h02, "R3 new byte after write");

    // R2 group mapping
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) begin
        bank_sel = 2'(b); rn_en = 1; rn_we = 1; rn_idx = 3'(i); rn_wdata = 8'(8'hA0 ^ (b * 8 + i)); tick();
      end
    end
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i += 3) dir_read(7'(b * 8 + i), "R2 register byte at 8*bank+idx");
      bank_sel = 2'(b); rn_en = 1; rn_we = 0; rn_idx = 3'd5; lbl_rn = "R2 register read per bank"; tick();
    end

    // R11 register port beats direct port on the same byte
    bank_sel = 2'd3; rn_en = 1; rn_we = 1; rn_idx = 3'd7; rn_wdata = 8'h11;
    dir_en = 1; dir_we = 1; dir_addr = 7'h1F; dir_wdata = 8'h22; tick();
    dir_read(7'h1F, "R11 register write wins");

    // R4 pushes from reset pointer
    push_req = 1; push_data = 8'h10; tick();
    chk("R4 sp after first push", sp_value, msp);
    push_req = 1; push_data = 8'h20; tick();
    push_req = 1; push_data = 8'h30; tick();
    chk("R4 sp after three pushes", sp_value, 8'h0A);
    dir_read(7'h08, "R4 first push lands at 08h");
    dir_read(7'h0A, "R4 third push at 0Ah");

    // R5 pops in reverse order
    for (int k = 0; k < 3; k++) begin
      pop_req = 1; lbl_pop = "R5 pop data"; tick();
      chk("R5 sp after pop", sp_value, msp);
    end
    chk("R5 sp back at 07h", sp_value, 8'h07);

    // R9 clash on byte 08h
    bank_sel = 2'd1; rn_en = 1; rn_we = 1; rn_idx = 3'd0; rn_wdata = 8'h55;
    push_req = 1; push_data = 8'hAA; tick();
    chk("R9 clash flag set", {7'b0, clash_flag}, {7'b0, exp_clash});
    dir_read(7'h08, "R9 pushed byte kept");
    bank_sel = 2'd1; rn_en = 1; rn_we = 1; rn_idx = 3'd3; rn_wdata = 8'h66;
    push_req = 1; push_data = 8'h77; tick();
    dir_read(7'h09, "R9 distinct push stored");
    dir_read(7'h0B, "R9 distinct register write stored");

    // R10 push with pop
    push_req = 1; push_data = 8'h99; pop_req = 1; lbl_pop = "R10 pop with push"; tick();
    chk("R10 sp after push+pop", sp_value, msp);
    dir_read(7'h0A, "R10 push not written");

    // R6 pointer load
    sp_load = 1; sp_load_val = 8'h30; tick();
    push_req = 1; push_data = 8'hC3; tick();
    chk("R6 sp after load and push", sp_value, 8'h31);
    dir_read(7'h31, "R6 push after load at 31h");
    sp_load = 1; sp_load_val = 8'h40; push_req = 1; push_data = 8'h5A; tick();
    chk("R6 load beats push", sp_value, 8'h40);
    dir_read(7'h41, "R6 ignored push left 41h");
    sp_load = 1; sp_load_val = 8'h50; pop_req = 1; tick();
    chk("R6 load beats pop", sp_value, 8'h50);
    chk("R7 no error on legal ops", {7'b0, stack_err}, 8'h00);

    // R7 overflow edge
    sp_load = 1; sp_load_val = 8'h7E; tick();
    push_req = 1; push_data = 8'hE1; tick();
    chk("R7 push at 7Eh accepted", sp_value, 8'h7F);
    push_req = 1; push_data = 8'hE2; tick();
    chk("R7 sp held on overflow", sp_value, 8'h7F);
    chk("R7 stack_err on overflow", {7'b0, stack_err}, 8'h01);
    dir_read(7'h00, "R7 RAM untouched at 00h");
    dir_read(7'h7F, "R7 top byte kept");
    sp_load = 1; sp_load_val = 8'h20; tick();
    push_req = 1; push_data = 8'h01; tick();
    chk("R7 stack_err sticky", {7'b0, stack_err}, 8'h01);

    // R1 reset clears flags and keeps RAM
    do_reset();
    chk("R1 sp after second reset", sp_value, 8'h07);
    chk("R1 flags cleared", {6'b0, stack_err, clash_flag}, 8'h00);
    dir_read(7'h7F, "R1 RAM kept over reset");

    // R8 underflow edge
    sp_load = 1; sp_load_val = 8'h01; tick();
    pop_req = 1; lbl_pop = "R8 pop at 01h accepted"; tick();
    chk("R8 sp after legal pop", sp_value, 8'h00);
    chk("R8 no error yet", {7'b0, stack_err}, 8'h00);
    pop_req = 1; tick();
    chk("R8 sp held at 00h", sp_value, 8'h00);
    chk("R8 stack_err on underflow", {7'b0, stack_err}, 8'h01);
    do_reset();
    sp_load = 1; sp_load_val = 8'h90; tick();
    pop_req = 1; tick();
    chk("R8 sp held above RAM", sp_value, 8'h90);
    chk("R8 stack_err above RAM", {7'b0, stack_err}, 8'h01);

    repeat (3) tick();
    chk("R3 all predicted reads returned", 8'(q_rn.size() + q_dir.size() + q_pop.size()), 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule